// File: doc/BRIEF.md
# Clock Generator Configuration Slave (I2C Block Transfer)

This block is the serial configuration port of a system clock generator. It sits on a two-wire I2C bus as a standard-mode slave (100 kbit/s or slower) and keeps seven 8-bit configuration bytes. A host writes them with a block write. The first two bytes after the address are a command code and a byte count. The slave acknowledges both and discards their values. The data bytes that follow are loaded into byte 0, byte 1 and so on, with no register addressing. A host reads them back with a block read. The slave first returns a byte count and then the bytes in order.

At power-on the block samples three frequency-select strap levels while reset is held. It keeps them for as long as it runs and reports them, inverted, in byte 1. Byte 0 chooses whether the strap code or a programmed 5-bit code drives the frequency-select output. It also carries the spread-spectrum enable and the output-disable control. Clock synthesis is outside this block. The frequency code, spread enable and output disable are its only functional outputs, and the full register image is also brought out.

The bus lines are sampled on a fast system clock. The link controller has eight named states:
- `ST_IDLE`: waiting for a start condition.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging an address that matched.
- `ST_WR_BYTE`: shifting in a written byte.
- `ST_WR_ACK`: acknowledging a written byte.
- `ST_RD_BYTE`: shifting out a byte.
- `ST_RD_ACK`: sampling the host's acknowledge.
- `ST_IGNORE`: deaf to the bus until the next start or stop.

Its transitions are as follows:
- A stop condition in any state leads to `ST_IDLE`.
- A start condition in any state (including a repeated start) leads to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the SCL fall after the eighth bit if the address matched. Otherwise it goes to `ST_IGNORE`.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE` on the next SCL fall, as the read/write bit selects.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits. It goes back on the following SCL fall.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` if the host acknowledged, or to `ST_IGNORE` if it did not.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset the register bytes read byte0=0x00, byte2=byte3=byte4=byte6=0xFF and byte5=0x06. Byte1 reads 0xFF in bits 4:0, with bits 7:5 as given by R2.
- R2: The 3-bit strap input is sampled on every clock edge while rst_n is low and held unchanged after reset ends. Byte1 bit 7 reads the inverse of strap bit 0, bit 6 the inverse of strap bit 1, and bit 5 the inverse of strap bit 2. Writes to these three bits have no visible effect.
- R3: The slave acknowledges only the 8-bit addresses 0xD2 (write) and 0xD3 (read). After any other address it acknowledges nothing and changes nothing until the next start condition. A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high.
- R4: In a write, the first two bytes after the address (command code and byte count) are acknowledged, and their values alter no register.
- R5: Write data bytes are stored in order from byte 0 upward, each on completion of its eighth bit. Bytes past the last transferred one keep their values. Data bytes beyond byte 6 are acknowledged and discarded.
- R6: A stop or start that arrives in the middle of a data byte discards that partial byte.
- R7: A read returns the byte count 0x07 first, then byte 0, byte 1 and so on, MSB first. It returns 0xFF after byte 6. A host not-acknowledge ends the read.
- R8: freq_code_o equals {byte0[2], byte0[7:4]} (byte0[2] as MSB) when byte0 bit 3 is 1. When bit 3 is 0 it equals {2'b00, strap[2:0]}.
- R9: spread_en_o follows byte0 bit 1 and outputs_off_o follows byte0 bit 0.
- R10: The slave pulls SDA low only in the acknowledge slot of an accepted address or written byte, and for 0 bits of read data. It starts pulling only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-on reset; straps are sampled while low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_fs_i | input | 3 | Frequency-select strap levels, meaningful during reset |
| freq_code_o | output | 5 | Selected frequency code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| outputs_off_o | output | 1 | Request to place all clock outputs in high impedance |
| cfg_o | output | 56 | Register image, byte n at bits 8n+7:8n |

## Verification
Each bus line passes two synchronizer flops and one edge flop. A change on SCL or SDA is therefore acted on three clocks later, and any register or drive update it causes is visible on the ports four clocks after the pin moved. Register contents and the derived frequency code are complete four clocks after the SCL fall that ends a data byte. The bench moves a bus line only once every quarter bit (eight clocks) and samples SDA at the middle of the SCL-high phase. It checks the register outputs only after a stop plus further quarter-bit waits, always on the falling system clock edge, so every result is settled well before it is read.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int unsigned CFG_BYTES = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } link_state_e;

    // Power-on value of each configuration byte
    function automatic logic [7:0] byte_reset_value(input int unsigned idx);
        if (idx == 0)      return 8'h00;
        else if (idx == 5) return 8'h06;
        else               return 8'hFF;
    endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // One synchronizer chain plus history flop per line: index 0 = SCL, 1 = SDA
    logic [1:0] line_in;
    logic [1:0] line_lvl;
    logic [1:0] line_prev;

    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        logic              prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
                prev_q <= 1'b1;
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], line_in[g]};
                prev_q <= pipe_q[STAGES-1];
            end
        end
        assign line_lvl[g]  = pipe_q[STAGES-1];
        assign line_prev[g] = prev_q;
    end

    assign scl_lvl   = line_lvl[0];
    assign sda_lvl   = line_lvl[1];
    assign scl_rise  =  line_lvl[0] & ~line_prev[0];
    assign scl_fall  = ~line_lvl[0] &  line_prev[0];
    assign start_det =  line_lvl[0] & line_prev[0] &  line_prev[1] & ~line_lvl[1];
    assign stop_det  =  line_lvl[0] & line_prev[0] & ~line_prev[1] &  line_lvl[1];

endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter  int unsigned NUM_BYTES = CFG_BYTES,
    parameter  int unsigned STRAP_W   = 3,
    parameter  int unsigned CODE_W    = 5,
    localparam int unsigned IDX_W     = $clog2(NUM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STRAP_W-1:0]     strap_i,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [8*NUM_BYTES-1:0] cfg_flat,
    output logic [CODE_W-1:0]      freq_code,
    output logic                   spread_en,
    output logic                   outputs_off
);
    logic [7:0]         mem_q  [NUM_BYTES];
    logic [7:0]         view   [NUM_BYTES];
    logic [STRAP_W-1:0] strap_q;

    // Straps follow the pins while reset is held, then freeze
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= byte_reset_value(i);
        end else if (wr_en && (32'(wr_idx) < NUM_BYTES)) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Byte 1 top bits show the inverted strap latch
    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) view[i] = mem_q[i];
        for (int k = 0; k < STRAP_W; k++) view[1][7-k] = ~strap_q[k];
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
        assign cfg_flat[8*g +: 8] = view[g];
    end

    always_comb begin
        rd_data     = (32'(rd_idx) < NUM_BYTES) ? view[rd_idx] : 8'hFF;
        freq_code   = view[0][3] ? CODE_W'({view[0][2], view[0][7:4]}) : CODE_W'(strap_q);
        spread_en   = view[0][1];
        outputs_off = view[0][0];
    end

endmodule

// File: rtl/clkcfg_link_fsm.sv
module clkcfg_link_fsm
    import clkcfg_pkg::*;
#(
    parameter  int unsigned NUM_BYTES = CFG_BYTES,
    parameter  logic [6:0]  DEV_ADDR  = 7'h69,
    localparam int unsigned IDX_W     = $clog2(NUM_BYTES),
    localparam int unsigned PH_W      = $clog2(NUM_BYTES + 3) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_lvl,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    link_state_e     state_q, state_d;
    logic [3:0]      bit_q;
    logic [7:0]      rx_q, tx_q, tx_next;
    logic [PH_W-1:0] ph_q;
    logic            rw_q, nak_q;
    logic            in_done, out_done, addr_hit;

    assign in_done  = scl_fall && (bit_q == 4'd8);
    assign out_done = scl_fall && (bit_q == 4'd7);
    assign addr_hit = (rx_q[7:1] == DEV_ADDR);

    // Next read byte: count, then register bytes, then filler
    always_comb begin
        rd_idx = IDX_W'(ph_q - PH_W'(1));
        if (ph_q == '0)                    tx_next = 8'(NUM_BYTES);
        else if (ph_q <= PH_W'(NUM_BYTES)) tx_next = rd_data;
        else                               tx_next = 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (in_done)  state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (in_done)  state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (out_done) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = nak_q ? ST_IGNORE : ST_RD_BYTE;
                ST_IGNORE:   state_d = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            rx_q  <= '0;
            tx_q  <= '1;
            ph_q  <= '0;
            rw_q  <= 1'b0;
            nak_q <= 1'b1;
        end else if (start_det || stop_det) begin
            bit_q <= '0;
            ph_q  <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_q  <= {rx_q[6:0], sda_lvl};
                        bit_q <= bit_q + 4'd1;
                    end else if (in_done) begin
                        bit_q <= '0;
                        if (state_q == ST_ADDR) rw_q <= rx_q[0];
                        else if (!(&ph_q))      ph_q <= ph_q + PH_W'(1);
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        tx_q <= tx_next;
                        ph_q <= ph_q + PH_W'(1);
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx_q  <= {tx_q[6:0], 1'b1};
                        bit_q <= out_done ? 4'd0 : bit_q + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        nak_q <= sda_lvl;
                    end else if (scl_fall && !nak_q) begin
                        tx_q <= tx_next;
                        if (!(&ph_q)) ph_q <= ph_q + PH_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_en   = (state_q == ST_WR_BYTE) && in_done &&
                  (ph_q >= PH_W'(2)) && (ph_q < PH_W'(NUM_BYTES + 2));
        wr_idx  = IDX_W'(ph_q - PH_W'(2));
        wr_data = rx_q;
        sda_oe  = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                  ((state_q == ST_RD_BYTE) && !tx_q[7]);
    end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter  int unsigned NUM_BYTES = CFG_BYTES,
    parameter  int unsigned SYNC_STG  = 2,
    parameter  logic [6:0]  DEV_ADDR  = 7'h69,
    localparam int unsigned IDX_W     = $clog2(NUM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [2:0]             strap_fs_i,
    output logic [4:0]             freq_code_o,
    output logic                   spread_en_o,
    output logic                   outputs_off_o,
    output logic [8*NUM_BYTES-1:0] cfg_o
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    clkcfg_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_link_fsm #(.NUM_BYTES(NUM_BYTES), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    clkcfg_regs #(.NUM_BYTES(NUM_BYTES), .STRAP_W(3), .CODE_W(5)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_fs_i),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .cfg_flat    (cfg_o),
        .freq_code   (freq_code_o),
        .spread_en   (spread_en_o),
        .outputs_off (outputs_off_o)
    );

endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk #(
    parameter int unsigned NUM_BYTES = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_lvl,
    input logic                   wr_en,
    input logic                   sda_oe_o,
    input logic [4:0]             freq_code_o,
    input logic [8*NUM_BYTES-1:0] cfg_o
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: strap view in byte 1 never moves after reset
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> $stable(cfg_o[15:13]));

    // R5: the register image changes only after a byte commit
    p_cfg_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_en)) |-> $stable(cfg_o));

    // R5: a committed byte is acknowledged in the next cycle
    p_commit_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe_o);

    // R10: the slave begins pulling SDA only while SCL is low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);

    // R8: programmed source selects the byte-0 code
    p_prog_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[3] |-> (freq_code_o == {cfg_o[2], cfg_o[7:4]}));

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .wr_en       (wr_en),
    .sda_oe_o    (sda_oe_o),
    .freq_code_o (freq_code_o),
    .cfg_o       (cfg_o)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb_top;

    localparam int QTR = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        bus_sda;
    logic        sda_oe_o;
    logic [2:0]  strap_fs_i = STRAP;
    logic [4:0]  freq_code_o;
    logic        spread_en_o, outputs_off_o;
    logic [55:0] cfg_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic contention = 1'b0;
    logic [7:0] model [7];
    logic [7:0] wbuf [12];

    always #2.5 clk = ~clk;

    assign bus_sda = host_sda & ~sda_oe_o;

    clkcfg_i2c_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (bus_sda),
        .sda_oe_o      (sda_oe_o),
        .strap_fs_i    (strap_fs_i),
        .freq_code_o   (freq_code_o),
        .spread_en_o   (spread_en_o),
        .outputs_off_o (outputs_off_o),
        .cfg_o         (cfg_o)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_view(input int i);
        if (i == 1) return {~STRAP[0], ~STRAP[1], ~STRAP[2], model[1][4:0]};
        return model[i];
    endfunction

    function automatic logic [4:0] exp_freq();
        return model[0][3] ? {model[0][2], model[0][7:4]} : {2'b00, STRAP};
    endfunction

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; q(); scl = 1'b1; q(); host_sda = 1'b0; q(); scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; q(); scl = 1'b1; q(); host_sda = 1'b1; q(); q();
    endtask

    task automatic send_bit(input logic b);
        host_sda = b; q(); scl = 1'b1; q();
        if (bus_sda !== b) contention = 1'b1;
        q(); scl = 1'b0; q();
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; q(); scl = 1'b1; q(); b = bus_sda; q(); scl = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic host_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~host_ack);
    endtask

    task automatic check_outputs(input string tag);
        for (int i = 0; i < 7; i++) chk(tag, 32'(cfg_o[8*i +: 8]), 32'(exp_view(i)));
        chk("R8 freq code", 32'(freq_code_o), 32'(exp_freq()));
        chk("R9 spread/off", {30'd0, spread_en_o, outputs_off_o}, {30'd0, model[0][1], model[0][0]});
    endtask

    // Block write of n data bytes from wbuf
    task automatic wr_txn(input int n);
        logic ack;
        contention = 1'b0;
        bus_start();
        send_byte(8'hD2, ack);              chk("R3 write address ack", 32'(ack), 1);
        send_byte(8'($urandom()), ack);     chk("R4 command ack", 32'(ack), 1);
        send_byte(8'($urandom()), ack);     chk("R4 count ack", 32'(ack), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk("R5 data ack", 32'(ack), 1);
        end
        bus_stop();
        for (int i = 0; i < n && i < 7; i++) model[i] = wbuf[i];
        chk("R10 no drive on host bits", 32'(contention), 0);
    endtask

    // Block read of k bytes, host NACKs the last one
    task automatic rd_txn(input int k);
        logic ack;
        logic [7:0] d;
        logic [7:0] e;
        bus_start();
        send_byte(8'hD3, ack); chk("R3 read address ack", 32'(ack), 1);
        for (int j = 0; j < k; j++) begin
            recv_byte(d, j != k - 1);
            e = (j == 0) ? 8'h07 : (j <= 7) ? exp_view(j - 1) : 8'hFF;
            chk("R7 read byte", 32'(d), 32'(e));
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic ack;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 7; i++) model[i] = (i == 0) ? 8'h00 : (i == 5) ? 8'h06 : 8'hFF;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        q();
        strap_fs_i = 3'b010;   // pins now carry clocks; latch must hold
        q();

        // R1 / R2 reset state
        check_outputs("R1 reset byte");
        chk("R2 strap view", 32'(cfg_o[15:8]), 32'h5F);
        chk("R8 strap code", 32'(freq_code_o), 32'h05);

        // Two bytes: programmed code, try to write strap bits
        wbuf[0] = 8'hA8; wbuf[1] = 8'h00;
        wr_txn(2);
        check_outputs("R5 two-byte write");
        chk("R2 strap bits unwritable", 32'(cfg_o[15:8]), 32'h40);
        chk("R8 programmed code", 32'(freq_code_o), 32'h0A);

        // Foreign address ignored
        bus_start();
        send_byte(8'hA0, ack); chk("R3 foreign address nak", 32'(ack), 0);
        send_byte(8'h00, ack); chk("R3 ignored after nak", 32'(ack), 0);
        send_byte(8'h55, ack); chk("R3 ignored after nak", 32'(ack), 0);
        bus_stop();
        check_outputs("R3 no change");

        // Partial data byte discarded
        bus_start();
        send_byte(8'hD2, ack); chk("R3 write address ack", 32'(ack), 1);
        send_byte(8'h11, ack); chk("R4 command ack", 32'(ack), 1);
        send_byte(8'h22, ack); chk("R4 count ack", 32'(ack), 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check_outputs("R6 partial byte");

        // Overflow past byte 6
        for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h30 + i);
        wr_txn(9);
        check_outputs("R5 overflow write");
        rd_txn(9);

        // Spread and output-disable, strap source
        wbuf[0] = 8'h03;
        wr_txn(1);
        check_outputs("R9 control bits");
        chk("R8 back to strap", 32'(freq_code_o), 32'h05);
        rd_txn(1);

        // Random mix
        for (int it = 0; it < 8; it++) begin
            int n;
            int k;
            n = int'($urandom_range(0, 9));
            k = int'($urandom_range(1, 9));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
            wr_txn(n);
            check_outputs("R5 random write");
            rd_txn(k);
        end

        finish_run();
    end

endmodule